// File: doc/BRIEF.md
# SM3 TT2 Round-Step Unit

This block carries out one "TT2" step of the SM3 hash compression function on 128-bit vector operands. It takes a 32-bit instruction word, decodes the three 5-bit register indices and the 2-bit lane selector, and hands the indices out so that an outside register file can fetch the three operands. The accumulator operand (which is also the write-back target), a second source and a third source then come back in as 128-bit values. The unit merges four steps into one. First, a bitwise choose across three lanes of the accumulator, with the top lane as the selector. Second, a four-term sum modulo 2^32. Third, a rotate-XOR mix on that sum. Fourth, a fixed reshuffle of the accumulator lanes, one of which is rotated by 19.

The input and the output each use a valid/ready handshake. With `PIPELINE = 1` one register stage sits between them, and back-pressure stalls that stage without losing data. With `PIPELINE = 0` the path is purely combinational. An instruction word whose fixed opcode bits do not match, or one that arrives while the feature-enable input is low, produces an illegal beat and no write-back. The reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `sm3_tt2_unit`

## Requirements
- R1: The word is legal only when feat_en is 1, insn[31:21] = 11'b11001110010, insn[15:14] = 2'b10 and insn[11:10] = 2'b11. The fields are decoded combinationally as follows: rm_idx = insn[20:16], lane selector = insn[13:12], rn_idx = insn[9:5], rd_idx = insn[4:0].
- R2: Lane k of a vector is bits 32k+31:32k. The intermediate C is (D3 AND D2) OR (NOT D3 AND D1), where Dk is lane k of op_d.
- R3: T = C + D0 + N3 + M[s] modulo 2^32. N3 is lane 3 of op_n, M[s] is lane s of op_m, and s is the lane selector.
- R4: out_result[127:96] = T XOR rotl(T,9) XOR rotl(T,17).
- R5: out_result[95:64] = D3, out_result[63:32] = rotl(D2,19) and out_result[31:0] = D1.
- R6: An illegal word raises out_illegal instead of out_valid for its beat, and out_result is all zeros during that beat.
- R7: With PIPELINE = 1, the beat for a word accepted on a clock edge is presented right after that edge. out_valid and out_illegal are never high together.
- R8: While a beat is presented and out_ready is low, in_ready is low and out_valid, out_illegal and out_result hold. A word waiting on the input is taken once out_ready returns, and no word is lost.
- R9: out_rd carries the rd_idx of the word that produced the presented beat.
- R10: While rst_n is low, out_valid, out_illegal and in_ready are 0. in_ready first rises on the second rising clock edge after rst_n is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| feat_en | input | 1 | SM3 feature enabled; when low, every word is illegal |
| in_valid | input | 1 | Instruction word and operands are offered |
| in_ready | output | 1 | Unit can take the offered word |
| insn | input | 32 | Instruction word |
| rd_idx | output | 5 | Decoded accumulator / destination index |
| rn_idx | output | 5 | Decoded second-source index |
| rm_idx | output | 5 | Decoded third-source index |
| op_d | input | 128 | Accumulator operand |
| op_n | input | 128 | Second source operand |
| op_m | input | 128 | Third source operand |
| out_valid | output | 1 | Legal result beat presented |
| out_illegal | output | 1 | Illegal-instruction beat presented |
| out_ready | input | 1 | Consumer takes the presented beat |
| out_result | output | 128 | Value to write back to rd |
| out_rd | output | 5 | Write-back index for the presented beat |

## Verification
The bench builds two copies of the unit that share one stimulus. The first uses PIPELINE = 1, which brings into reach the one-cycle latency, the stall-and-resume behaviour under a held out_ready, and the reset-release timing. The second uses PIPELINE = 0, which allows every word's lane arithmetic and decode to be compared in the same cycle the word is driven. Random operands, all four lane selectors, all-ones lanes that force the sum to wrap, single flipped opcode bits and a disabled feature are each compared against a behavioural model.

// File: rtl/sm3_tt2_pkg.sv
package sm3_tt2_pkg;
  parameter int unsigned LANE_W    = 32;
  parameter int unsigned NUM_LANES = 4;
  parameter int unsigned IDX_W     = 5;
  parameter int unsigned INSN_W    = 32;

  localparam int unsigned VEC_W = LANE_W * NUM_LANES;
  localparam int unsigned SEL_W = $clog2(NUM_LANES);

  // fixed opcode fields
  localparam logic [10:0] OPC_HI  = 11'b11001110010;
  localparam logic [1:0]  OPC_MID = 2'b10;
  localparam logic [1:0]  OPC_LO  = 2'b11;

  typedef logic [LANE_W-1:0] lane_t;

  typedef struct packed {
    logic             legal;
    logic [IDX_W-1:0] rd;
    logic [IDX_W-1:0] rn;
    logic [IDX_W-1:0] rm;
    logic [SEL_W-1:0] sel;
  } dec_t;

  function automatic lane_t rotl(input lane_t x, input int unsigned s);
    return (x << s) | (x >> (LANE_W - s));
  endfunction
endpackage

// File: rtl/sm3_tt2_rst_sync.sv
module sm3_tt2_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/sm3_tt2_decode.sv
module sm3_tt2_decode
  import sm3_tt2_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  input  logic              feat_en,
  output dec_t              dec
);
  logic match_hi, match_mid, match_lo;

  always_comb begin
    match_hi  = (insn[31:21] == OPC_HI);
    match_mid = (insn[15:14] == OPC_MID);
    match_lo  = (insn[11:10] == OPC_LO);
    dec.legal = feat_en & match_hi & match_mid & match_lo;
    dec.rm    = insn[20:16];
    dec.sel   = insn[13:12];
    dec.rn    = insn[9:5];
    dec.rd    = insn[4:0];
  end
endmodule

// File: rtl/sm3_tt2_core.sv
module sm3_tt2_core
  import sm3_tt2_pkg::*;
#(
  parameter int unsigned ROT_A = 9,
  parameter int unsigned ROT_B = 17,
  parameter int unsigned ROT_S = 19
) (
  input  logic [VEC_W-1:0] acc_vec,
  input  logic [VEC_W-1:0] src_vec,
  input  logic [VEC_W-1:0] sel_vec,
  input  logic [SEL_W-1:0] sel,
  output logic [VEC_W-1:0] result
);
  localparam int unsigned TOP = NUM_LANES - 1;

  lane_t acc_l [NUM_LANES];
  lane_t src_l [NUM_LANES];
  lane_t sel_l [NUM_LANES];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_unpack
    assign acc_l[g] = acc_vec[g*LANE_W +: LANE_W];
    assign src_l[g] = src_vec[g*LANE_W +: LANE_W];
    assign sel_l[g] = sel_vec[g*LANE_W +: LANE_W];
  end

  lane_t chosen, summed, mixed;

  always_comb begin
    chosen = (acc_l[TOP] & acc_l[TOP-1]) | (~acc_l[TOP] & acc_l[TOP-2]);
    summed = chosen + acc_l[0] + src_l[TOP] + sel_l[sel];
    mixed  = summed ^ rotl(summed, ROT_A) ^ rotl(summed, ROT_B);
    result = {mixed, acc_l[TOP], rotl(acc_l[TOP-1], ROT_S), acc_l[TOP-2]};
  end
endmodule

// File: rtl/sm3_tt2_stage.sv
module sm3_tt2_stage
  import sm3_tt2_pkg::*;
(
  input  logic             clk,
  input  logic             srst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             legal,
  input  logic [VEC_W-1:0] result,
  input  logic [IDX_W-1:0] rd,
  output logic             out_valid,
  output logic             out_illegal,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_result,
  output logic [IDX_W-1:0] out_rd
);
  logic             full_q, full_d;
  logic             legal_q, legal_d;
  logic [VEC_W-1:0] res_q, res_d;
  logic [IDX_W-1:0] rd_q, rd_d;
  logic             hold, accept, full_en;

  always_comb begin
    hold     = full_q & ~out_ready;
    in_ready = srst_n & ~hold;
    accept   = in_valid & in_ready;
    full_en  = accept | out_ready;
    full_d   = accept;
    legal_d  = legal;
    res_d    = legal ? result : '0;
    rd_d     = rd;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      full_q  <= 1'b0;
      legal_q <= 1'b0;
      res_q   <= '0;
      rd_q    <= '0;
    end else begin
      if (full_en) full_q <= full_d;
      if (accept) begin
        legal_q <= legal_d;
        res_q   <= res_d;
        rd_q    <= rd_d;
      end
    end
  end

  assign out_valid   = full_q & legal_q;
  assign out_illegal = full_q & ~legal_q;
  assign out_result  = res_q;
  assign out_rd      = rd_q;
endmodule

// File: rtl/sm3_tt2_unit.sv
module sm3_tt2_unit
  import sm3_tt2_pkg::*;
#(
  parameter int unsigned PIPELINE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              feat_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INSN_W-1:0] insn,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [IDX_W-1:0]  rn_idx,
  output logic [IDX_W-1:0]  rm_idx,
  input  logic [VEC_W-1:0]  op_d,
  input  logic [VEC_W-1:0]  op_n,
  input  logic [VEC_W-1:0]  op_m,
  output logic              out_valid,
  output logic              out_illegal,
  input  logic              out_ready,
  output logic [VEC_W-1:0]  out_result,
  output logic [IDX_W-1:0]  out_rd
);
  logic             srst_n;
  dec_t             dec;
  logic [VEC_W-1:0] step_res;

  sm3_tt2_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  sm3_tt2_decode u_dec (
    .insn    (insn),
    .feat_en (feat_en),
    .dec     (dec)
  );

  assign rd_idx = dec.rd;
  assign rn_idx = dec.rn;
  assign rm_idx = dec.rm;

  sm3_tt2_core u_core (
    .acc_vec (op_d),
    .src_vec (op_n),
    .sel_vec (op_m),
    .sel     (dec.sel),
    .result  (step_res)
  );

  if (PIPELINE != 0) begin : g_reg
    sm3_tt2_stage u_stage (
      .clk         (clk),
      .srst_n      (srst_n),
      .in_valid    (in_valid),
      .in_ready    (in_ready),
      .legal       (dec.legal),
      .result      (step_res),
      .rd          (dec.rd),
      .out_valid   (out_valid),
      .out_illegal (out_illegal),
      .out_ready   (out_ready),
      .out_result  (out_result),
      .out_rd      (out_rd)
    );
  end else begin : g_comb
    always_comb begin
      in_ready    = srst_n & out_ready;
      out_valid   = srst_n & in_valid & dec.legal;
      out_illegal = srst_n & in_valid & ~dec.legal;
      out_result  = dec.legal ? step_res : '0;
      out_rd      = dec.rd;
    end
  end
endmodule

// File: rtl/sm3_tt2_chk.sv
module sm3_tt2_chk
  import sm3_tt2_pkg::*;
#(
  parameter int unsigned PIPELINE = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_illegal,
  input logic             out_ready,
  input logic [VEC_W-1:0] out_result
);
  // R7
  no_dual_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_illegal));

  // R6
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> (out_result == '0));

  if (PIPELINE != 0) begin : g_pipe
    // R7
    one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_valid || out_illegal));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((out_valid || out_illegal) && !out_ready) |=>
        ($stable(out_result) && $stable(out_valid) && $stable(out_illegal)));

    // R8
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((out_valid || out_illegal) && !out_ready) |-> !in_ready);
  end
endmodule

bind sm3_tt2_unit sm3_tt2_chk #(.PIPELINE(PIPELINE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_illegal (out_illegal),
  .out_ready   (out_ready),
  .out_result  (out_result)
);

// File: tb/sm3_tt2_unit_test.sv
module sm3_tt2_unit_test;
  localparam int HALF = 2; // 250 MHz

  logic         clk = 0;
  logic         rst_n = 0;
  logic         feat_en = 1;
  logic         in_valid = 0;
  logic [31:0]  insn = '0;
  logic [127:0] op_d = '0, op_n = '0, op_m = '0;
  logic         out_ready = 1;

  logic         in_ready, out_valid, out_illegal;
  logic [127:0] out_result;
  logic [4:0]   rd_idx, rn_idx, rm_idx, out_rd;
  logic         c_in_ready, c_out_valid, c_out_illegal;
  logic [127:0] c_out_result;
  logic [4:0]   c_rd, c_rn, c_rm, c_out_rd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #HALF clk = ~clk;

  sm3_tt2_unit #(.PIPELINE(1)) uut (
    .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .in_valid(in_valid),
    .in_ready(in_ready), .insn(insn), .rd_idx(rd_idx), .rn_idx(rn_idx),
    .rm_idx(rm_idx), .op_d(op_d), .op_n(op_n), .op_m(op_m),
    .out_valid(out_valid), .out_illegal(out_illegal), .out_ready(out_ready),
    .out_result(out_result), .out_rd(out_rd));

  sm3_tt2_unit #(.PIPELINE(0)) uut_comb (
    .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .in_valid(in_valid),
    .in_ready(c_in_ready), .insn(insn), .rd_idx(c_rd), .rn_idx(c_rn),
    .rm_idx(c_rm), .op_d(op_d), .op_n(op_n), .op_m(op_m),
    .out_valid(c_out_valid), .out_illegal(c_out_illegal), .out_ready(1'b1),
    .out_result(c_out_result), .out_rd(c_out_rd));

  function automatic logic [31:0] rl(input logic [31:0] x, input int s);
    return (x << s) | (x >> (32 - s));
  endfunction

  function automatic logic [31:0] make_insn(input logic [4:0] d, input logic [4:0] n,
                                            input logic [4:0] m, input logic [1:0] s);
    return {11'b11001110010, m, 2'b10, s, 2'b11, n, d};
  endfunction

  function automatic bit is_legal(input logic [31:0] w, input logic fe);
    return fe && w[31:21] == 11'b11001110010 && w[15:14] == 2'b10 && w[11:10] == 2'b11;
  endfunction

  function automatic logic [127:0] model(input logic [31:0] w, input logic [127:0] d,
                                         input logic [127:0] n, input logic [127:0] m);
    logic [31:0] d0, d1, d2, d3, c, t, wj;
    d0 = d[31:0]; d1 = d[63:32]; d2 = d[95:64]; d3 = d[127:96];
    wj = m[32*w[13:12] +: 32];
    c  = (d3 & d2) | (~d3 & d1);
    t  = c + d0 + n[127:96] + wj;
    return {t ^ rl(t, 9) ^ rl(t, 17), d3, rl(d2, 19), d1};
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected values of the op currently applied
  logic [127:0] e_res;
  logic         e_leg;

  task automatic compare_beat(input string tag, input logic v, input logic il,
                              input logic [127:0] r, input logic [4:0] rdo);
    chk({tag, " R6/R7 flags"}, {126'd0, v, il}, {126'd0, e_leg, !e_leg});
    chk({tag, " R2/R3/R4/R5/R6 result"}, r, e_leg ? e_res : 128'd0);
    chk({tag, " R9 out_rd"}, {123'd0, rdo}, {123'd0, insn[4:0]});
  endtask

  task automatic run_op(input logic [31:0] w, input logic fe, input logic [127:0] d,
                        input logic [127:0] n, input logic [127:0] m);
    @(negedge clk);
    insn = w; feat_en = fe; op_d = d; op_n = n; op_m = m; in_valid = 1;
    e_leg = is_legal(w, fe);
    e_res = model(w, d, n, m);
    #1;
    chk("R1 indices", {113'd0, c_rd, c_rn, c_rm}, {113'd0, w[4:0], w[9:5], w[20:16]});
    compare_beat("comb", c_out_valid, c_out_illegal, c_out_result, c_out_rd);
    @(negedge clk);
    compare_beat("pipe", out_valid, out_illegal, out_result, out_rd);
    in_valid = 0;
  endtask

  function automatic logic [127:0] rv();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic [127:0] a_exp;
    logic [4:0] a_rd;
    void'($urandom(32'h5EED_0C3A));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset flags", {125'd0, out_valid, out_illegal, in_ready}, 128'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R10 in_ready after one edge", {127'd0, in_ready}, 128'd0);
    @(negedge clk);
    chk("R10 in_ready after two edges", {127'd0, in_ready}, 128'd1);

    // R3 all four lane selectors, all-ones carry wrap
    for (int s = 0; s < 4; s++)
      run_op(make_insn(5'd1 + 5'(s), 5'd7, 5'd30, 2'(s)), 1'b1,
             {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF},
             {32'hFFFF_FFFF, 96'd0}, {32'h4, 32'h3, 32'h2, 32'h1});
    // R2 choose with alternating selector
    run_op(make_insn(5'd31, 5'd0, 5'd0, 2'd2), 1'b1,
           {32'hF0F0_A5A5, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0}, 128'd0, 128'd0);
    // R5 lane shuffle alone
    run_op(make_insn(5'd0, 5'd0, 5'd0, 2'd0), 1'b1,
           {32'h8000_0001, 32'h0000_0001, 32'hDEAD_BEEF, 32'hFFFF_FFFF},
           {96'd0, 32'hFFFF_FFFF}, {96'd0, 32'h1});
    // R6 feature disabled
    run_op(make_insn(5'd9, 5'd8, 5'd7, 2'd1), 1'b0, rv(), rv(), rv());
    // R1/R6 each fixed opcode bit flipped
    for (int b = 0; b < 32; b++)
      if (b >= 21 || b == 15 || b == 14 || b == 11 || b == 10)
        run_op(make_insn(5'd3, 5'd4, 5'd5, 2'd3) ^ (32'd1 << b), 1'b1, rv(), rv(), rv());

    // random mix
    for (int k = 0; k < 400; k++) begin
      w = make_insn(5'($urandom), 5'($urandom), 5'($urandom), 2'($urandom));
      if ($urandom_range(9) == 0) w = w ^ (32'd1 << $urandom_range(31));
      run_op(w, $urandom_range(15) != 0, rv(), rv(), rv());
    end

    // R8 stall with a second word waiting
    @(negedge clk);
    out_ready = 0;
    w = make_insn(5'd11, 5'd12, 5'd13, 2'd1);
    insn = w; feat_en = 1; op_d = rv(); op_n = rv(); op_m = rv(); in_valid = 1;
    a_exp = model(w, op_d, op_n, op_m); a_rd = 5'd11;
    @(negedge clk);
    w = make_insn(5'd21, 5'd22, 5'd23, 2'd3);
    insn = w; op_d = rv(); op_n = rv(); op_m = rv();
    e_res = model(w, op_d, op_n, op_m); e_leg = 1;
    chk("R8 first beat shown", out_result, a_exp);
    chk("R8 in_ready low in stall", {127'd0, in_ready}, 128'd0);
    @(negedge clk);
    chk("R8 held result", out_result, a_exp);
    chk("R8 held flags/rd", {122'd0, out_valid, out_illegal, out_rd},
        {122'd0, 1'b1, 1'b0, a_rd});
    chk("R8 in_ready still low", {127'd0, in_ready}, 128'd0);
    out_ready = 1;
    @(negedge clk);
    compare_beat("R8 waiting word", out_valid, out_illegal, out_result, out_rd);
    in_valid = 0;
    @(negedge clk);
    chk("R8 drained", {126'd0, out_valid, out_illegal}, 128'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule